// File: doc/BRIEF.md
# Up/down binary counter with asynchronous load

This block is a four-bit binary counter whose state steps by one on each rising clock edge, either upward or downward depending on a direction input, while an active-low enable is asserted. Beside the clocked path it has two asynchronous controls. The first is an active-low master clear that forces the count to zero. The second is a level-sensitive load. While the load is high, the count takes on the data inputs and keeps following them, with no clock needed.

An active-low terminal-count output shows that the next enabled step would wrap. In the upward direction this is the all-ones state, and in the downward direction it is the all-zeros state. The output is decoded combinationally from the count, the direction and the enable. Each count bit is stored in a flop that has its own asynchronous set and clear. Both come from the clear input, the load input and that bit's data input. This keeps the load transparent without a separate latch.

Top module: `updown_load_counter`

## Requirements
- R1: While rst_ni is 0, count_o is 0 whatever load_i, data_i, en_ni, up_i and the clock do.
- R2: While rst_ni is 1 and load_i is 1, count_o equals data_i and follows every change of data_i without a clock edge. Clock edges in this state do not step the count.
- R3: When load_i falls between clock edges, count_o keeps the last data_i value present while load_i was high. Later changes of data_i have no effect until the next load.
- R4: With rst_ni 1, load_i 0 and en_ni 1, count_o holds its value across clock edges.
- R5: With rst_ni 1, load_i 0, en_ni 0 and up_i 1, each rising clock edge adds one, modulo 16 (15 goes to 0).
- R6: With rst_ni 1, load_i 0, en_ni 0 and up_i 0, each rising clock edge subtracts one, modulo 16 (0 goes to 15).
- R7: tc_no is 0 exactly when en_ni is 0 and either up_i is 1 with count_o = 15, or up_i is 0 with count_o = 0. Otherwise it is 1, and it is always 1 while en_ni is 1.
- R8: tc_no reflects a count changed by load or clear immediately, before any clock edge.
- R9: After clear or load is released between edges, the first rising edge that follows moves the count by exactly one enabled step from the value that was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_ni | input | 1 | Asynchronous master clear, active low, highest priority |
| load_i | input | 1 | Asynchronous transparent load, active high |
| data_i | input | 4 | Parallel load value |
| en_ni | input | 1 | Count enable, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| count_o | output | 4 | Current count |
| tc_no | output | 1 | Terminal count, active low |

## Verification
The overlaps that matter are a clock edge arriving while the asynchronous load or clear is still asserted, and an enabled count combined with a terminal-count decode at the wrap states. The bench holds load or clear high across rising edges with the enable active, changes data while the load is high, and releases the controls in the middle of a cycle. A reference model in the bench applies the priority clear, load, hold, count. Each random or directed step is judged twice: once between edges for the asynchronous value and tc_no, and once after the edge for the clocked result.

// File: rtl/updown_load_counter_pkg.sv
`timescale 1ns/1ps
package updown_load_counter_pkg;

  localparam int unsigned CNT_W_DEF = 4;

  typedef struct packed {
    logic set;
    logic clr;
  } async_ctl_t;

  // clear wins over load; load forces each bit to its data value
  function automatic async_ctl_t async_ctl(input logic rst_n, input logic load, input logic d);
    async_ctl_t c;
    c.clr = ~rst_n | (load & ~d);
    c.set = rst_n & load & d;
    return c;
  endfunction

endpackage

// File: rtl/ud_cnt_bit.sv
`timescale 1ns/1ps
module ud_cnt_bit (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  // set and clear are never high together
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end

endmodule

// File: rtl/ud_cnt_next.sv
`timescale 1ns/1ps
module ud_cnt_next #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic         en_ni,
  input  logic         up_i,
  output logic [W-1:0] nxt_o
);

  logic [W-1:0] run_up;
  logic [W-1:0] run_dn;
  logic [W-1:0] tog;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign run_up[i] = 1'b1;
      assign run_dn[i] = 1'b1;
    end else begin : g_upper
      assign run_up[i] = run_up[i-1] & q_i[i-1];
      assign run_dn[i] = run_dn[i-1] & ~q_i[i-1];
    end
    assign tog[i]   = ~en_ni & (up_i ? run_up[i] : run_dn[i]);
    assign nxt_o[i] = q_i[i] ^ tog[i];
  end

endmodule

// File: rtl/ud_cnt_tc.sv
`timescale 1ns/1ps
module ud_cnt_tc #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] cnt_i,
  input  logic         en_ni,
  input  logic         up_i,
  output logic         tc_no
);

  logic all_one;
  logic all_zero;

  assign all_one  = &cnt_i;
  assign all_zero = ~|cnt_i;
  assign tc_no    = ~(~en_ni & (up_i ? all_one : all_zero));

endmodule

// File: rtl/updown_load_counter.sv
`timescale 1ns/1ps
module updown_load_counter
  import updown_load_counter_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             en_ni,
  input  logic             up_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_no
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  async_ctl_t [CNT_W-1:0] ctl;

  ud_cnt_next #(.W(CNT_W)) u_next (
    .q_i   (cnt_q),
    .en_ni (en_ni),
    .up_i  (up_i),
    .nxt_o (cnt_nxt)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_cell
    assign ctl[i] = async_ctl(rst_ni, load_i, data_i[i]);
    ud_cnt_bit u_bit (
      .clk_i (clk_i),
      .set_i (ctl[i].set),
      .clr_i (ctl[i].clr),
      .d_i   (cnt_nxt[i]),
      .q_o   (cnt_q[i])
    );
  end

  ud_cnt_tc #(.W(CNT_W)) u_tc (
    .cnt_i (cnt_q),
    .en_ni (en_ni),
    .up_i  (up_i),
    .tc_no (tc_no)
  );

  assign count_o = cnt_q;

  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (count_o == data_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || load_i)
    en_ni |=> (count_o == $past(count_o)));

  // R5
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || load_i)
    (!en_ni && up_i) |=> (count_o == CNT_W'($past(count_o) + ONE)));

  // R6
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || load_i)
    (!en_ni && !up_i) |=> (count_o == CNT_W'($past(count_o) - ONE)));

  // R7
  tc_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_no |-> !en_ni);

endmodule

// File: tb/updown_load_counter_tb.sv
`timescale 1ns/1ps
module updown_load_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] data = 4'd0;
  logic       en_n = 1'b1;
  logic       up = 1'b1;
  logic [3:0] count;
  logic       tc_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] m = 4'd0;

  always #10 clk = ~clk;

  updown_load_counter u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .load_i  (load),
    .data_i  (data),
    .en_ni   (en_n),
    .up_i    (up),
    .count_o (count),
    .tc_no   (tc_n)
  );

  function automatic logic tc_ref(input logic [3:0] c, input logic e_n, input logic u);
    if (e_n) return 1'b1;
    return u ? (c != 4'hF) : (c != 4'h0);
  endfunction

  function automatic logic [3:0] step_ref(input logic [3:0] c, input logic e_n, input logic u);
    if (e_n) return c;
    return u ? c + 4'd1 : c - 4'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input string what, input logic [3:0] exp);
    chk(count === exp, req, what, int'(count), int'(exp));
  endtask

  task automatic chk_tc(input string req, input string what);
    logic e;
    e = tc_ref(count, en_n, up);
    chk(tc_n === e, req, what, int'(tc_n), int'(e));
  endtask

  // one cycle: drive after falling edge, judge async value, then judge after rising edge
  task automatic step(input logic r, input logic l, input logic [3:0] d, input logic e, input logic u);
    logic [3:0] pre;
    @(negedge clk);
    #1;
    rst_n = r; load = l; data = d; en_n = e; up = u;
    #2;
    pre = !r ? 4'd0 : (l ? d : m);
    chk_cnt(!r ? "R1" : (l ? "R2" : "R4"), "async value", pre);
    chk_tc(l || !r ? "R8" : "R7", "tc before edge");
    @(posedge clk);
    #2;
    m = (!r || l) ? pre : step_ref(pre, e, u);
    chk_cnt(!r ? "R1" : (l ? "R2" : (e ? "R4" : (u ? "R5" : "R6"))), "after edge", m);
    chk_tc("R7", "tc after edge");
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd24681357);
    #1;
    chk_cnt("R1", "reset state", 4'd0);
    step(1'b0, 1'b1, 4'd9, 1'b0, 1'b1);
    // R1 clear overrides load and count
    chk_cnt("R1", "clear over load", 4'd0);

    // R5 R7 up wrap
    step(1'b1, 1'b1, 4'd14, 1'b0, 1'b1);
    step(1'b1, 1'b0, 4'd0, 1'b0, 1'b1);
    chk_tc("R7", "up terminal at 15");
    chk(tc_n === 1'b0, "R7", "tc low at 15 up", int'(tc_n), 0);
    step(1'b1, 1'b0, 4'd0, 1'b0, 1'b1);
    chk_cnt("R5", "wrap 15 to 0", 4'd0);
    // R6 down wrap
    step(1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
    chk_cnt("R6", "wrap 0 to 15", 4'd15);
    // R7 enable high forces tc high at 15
    step(1'b1, 1'b0, 4'd0, 1'b1, 1'b1);
    chk(tc_n === 1'b1, "R7", "tc high with enable off", int'(tc_n), 1);

    // R2 R3 R9 transparency and release
    @(negedge clk); #1;
    load = 1'b1; data = 4'd3; en_n = 1'b0; up = 1'b1;
    #2; chk_cnt("R2", "follow 3", 4'd3);
    #3; data = 4'd9;
    #2; chk_cnt("R2", "follow 9 no clock", 4'd9);
    chk_tc("R8", "tc tracks load");
    @(posedge clk); #2;
    chk_cnt("R2", "no count while load high", 4'd9);
    @(negedge clk); #3;
    load = 1'b0;
    #1; data = 4'd5;
    #2; chk_cnt("R3", "held after release", 4'd9);
    @(posedge clk); #2;
    chk_cnt("R9", "one step after load release", 4'd10);
    m = 4'd10;
    // R8 load to 0 counting down gives immediate terminal
    @(negedge clk); #1;
    load = 1'b1; data = 4'd0; up = 1'b0;
    #2; chk(tc_n === 1'b0, "R8", "tc low on load 0 down", int'(tc_n), 0);
    @(posedge clk); #2;
    @(negedge clk); #3; load = 1'b0;
    // R9 clear release mid-cycle then one step
    @(posedge clk); #2; m = 4'd15;
    chk_cnt("R9", "step after load", 4'd15);
    @(negedge clk); #1; rst_n = 1'b0;
    #2; chk_cnt("R1", "clear mid-cycle", 4'd0);
    chk(tc_n === 1'b0, "R8", "tc after clear down", int'(tc_n), 0);
    @(posedge clk); #2;
    @(negedge clk); #3; rst_n = 1'b1; up = 1'b1;
    @(posedge clk); #2;
    chk_cnt("R9", "one step after clear release", 4'd1);
    m = 4'd1;

    for (int k = 0; k < 400; k++) begin
      logic r, l, e, u;
      logic [3:0] d;
      r = ($urandom % 16) != 0;
      l = ($urandom % 8) == 0;
      e = ($urandom % 4) == 0;
      u = $urandom % 2;
      d = 4'($urandom);
      step(r, l, d, e, u);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule